// File: doc/BRIEF.md
# Parity Small-Write Stripe Updater

This block manages a small array of lane memories that hold block-striped data plus one parity block per stripe. A host asks for one logical block at a time over a request/acknowledge handshake. A read of a healthy block streams the words of that block out of the single lane that holds it. A write runs a read-modify-write parity update and touches only two lanes. It reads the old data word and the old parity word, takes the new word from the host, and folds the three into a new parity. It then writes the data lane, writes the parity lane, and only then acknowledges.

A mode input chooses where parity lives. In the fixed mode parity always sits on the highest lane. In the rotating mode the parity lane moves from stripe to stripe, so writes that land in different stripes update parity on different lanes. A lane can be marked as failed. A read aimed at that lane is then rebuilt as the XOR of the same word in every other lane of the stripe.

Top module: `par_stripe_writer`

## Requirements
- R1: After reset every lane word is zero, `ack`, `rd_vld` and `wd_take` are low, and `lane_rd` and `lane_wr` are all-zero.
- R2: With D = LANES-1 data blocks per stripe, logical block b lies in stripe s = b / D at position k = b mod D. Its data lane is the k-th lane, counted in ascending order, among the lanes that are not the stripe's parity lane. Word i of the block sits at lane offset s*BLK_WORDS + i.
- R3: With `rot_mode` low at acceptance, the parity lane of every stripe is lane LANES-1.
- R4: With `rot_mode` high at acceptance, the parity lane of stripe s is (LANES-1) - (s mod LANES).
- R5: A read with `req_wr` low on a healthy target produces BLK_WORDS words on `rd_data` with `rd_vld` high, in word order, on consecutive cycles. The first word comes in the cycle after acceptance. In each of these cycles `lane_rd` has only the data lane's bit set (bit n = lane n).
- R6: A write with `req_wr` high runs four phases of BLK_WORDS cycles each, starting the cycle after acceptance. First, old-word reads with `lane_rd` = data lane | parity lane. Second, new-word intake with `wd_take` high, where `wd_data` is captured in word order. Third, `lane_wr` = data lane only. Fourth, `lane_wr` = parity lane only. No other lane is ever written.
- R7: Each new parity word equals old parity XOR old data XOR new data, so a stripe's parity lane stays the XOR of its data lanes.
- R8: `ack` is a single-cycle pulse one cycle after the last word of a read, or one cycle after the last parity write of a write. It is never raised earlier.
- R9: A read whose data lane equals `fail_lane` while `fail_en` is high returns, for each word, the XOR of that word across all other lanes. `lane_rd` then has every bit set except `fail_lane`.
- R10: With `fail_en` high but `fail_lane` different from the target's data lane, a read behaves exactly as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rot_mode | input | 1 | 1 = parity rotates per stripe, 0 = fixed parity lane |
| fail_en | input | 1 | A lane is marked failed |
| fail_lane | input | $clog2(LANES) | Index of the failed lane |
| req | input | 1 | Request, held until `ack` |
| req_wr | input | 1 | 1 = block write, 0 = block read |
| req_blk | input | $clog2(STRIPES*(LANES-1)) | Logical block number |
| ack | output | 1 | Request complete (one-cycle pulse) |
| wd_take | output | 1 | New write word consumed this cycle |
| wd_data | input | WORD_W | New write word |
| rd_vld | output | 1 | Read word valid |
| rd_data | output | WORD_W | Read word |
| lane_rd | output | LANES | Lanes read this cycle |
| lane_wr | output | LANES | Lanes written this cycle |

## Verification
The bench uses the defaults: four lanes, eight stripes, four words per block and 16-bit words. With eight stripes and four lanes, the rotating parity lane wraps twice, so every lane serves as parity for some stripe and as the target data lane for some block. Four-word blocks are enough to show word ordering within each phase, and small enough that every phase boundary is checked cycle by cycle. Degraded reads of blocks written in both modes confirm that the parity the block wrote rebuilds the lost data.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_OLD,
    ST_MIX,
    ST_WDAT,
    ST_WPAR,
    ST_DONE
  } psw_state_e;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/psw_lane_map.sv
module psw_lane_map #(
  parameter int LANES   = 4,
  parameter int STRIPES = 8
) (
  input  logic                                 rot,
  input  logic [$clog2(STRIPES*(LANES-1))-1:0] blk,
  output logic [$clog2(STRIPES)-1:0]           stripe,
  output logic [$clog2(LANES)-1:0]             dlane,
  output logic [$clog2(LANES)-1:0]             plane
);
  localparam int DL = LANES - 1;
  localparam int BW = $clog2(STRIPES*DL);
  localparam int LW = $clog2(LANES);
  localparam int SW = $clog2(STRIPES);

  logic [BW-1:0] quo, rem;
  logic [LW-1:0] pos, smod;

  always_comb begin
    quo    = blk / BW'(DL);
    rem    = blk % BW'(DL);
    pos    = LW'(rem);
    stripe = SW'(quo);
    smod   = LW'(quo % BW'(LANES));
    plane  = rot ? (LW'(LANES-1) - smod) : LW'(LANES-1);
    dlane  = (pos < plane) ? pos : (pos + LW'(1));
  end
endmodule

// File: rtl/psw_lane_mem.sv
module psw_lane_mem #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rdata
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/par_stripe_writer.sv
module par_stripe_writer #(
  parameter int LANES     = 4,
  parameter int STRIPES   = 8,
  parameter int BLK_WORDS = 4,
  parameter int WORD_W    = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rot_mode,
  input  logic                                 fail_en,
  input  logic [$clog2(LANES)-1:0]             fail_lane,
  input  logic                                 req,
  input  logic                                 req_wr,
  input  logic [$clog2(STRIPES*(LANES-1))-1:0] req_blk,
  output logic                                 ack,
  output logic                                 wd_take,
  input  logic [WORD_W-1:0]                    wd_data,
  output logic                                 rd_vld,
  output logic [WORD_W-1:0]                    rd_data,
  output logic [LANES-1:0]                     lane_rd,
  output logic [LANES-1:0]                     lane_wr
);
  import psw_pkg::*;

  localparam int DL    = LANES - 1;
  localparam int LW    = $clog2(LANES);
  localparam int BW    = $clog2(STRIPES*DL);
  localparam int SW    = $clog2(STRIPES);
  localparam int IW    = $clog2(BLK_WORDS);
  localparam int DEPTH = STRIPES * BLK_WORDS;
  localparam int AW    = $clog2(DEPTH);

  logic              rst_sn;
  psw_state_e        state_q, state_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [BW-1:0]     blk_q;
  logic              wr_q, rot_q, cap, last;
  logic [SW-1:0]     stripe;
  logic [LW-1:0]     dlane, plane;
  logic [WORD_W-1:0] lane_q [LANES];
  logic [WORD_W-1:0] pbuf_q [BLK_WORDS];
  logic [WORD_W-1:0] newb_q [BLK_WORDS];
  logic [AW-1:0]     mem_addr;
  logic [WORD_W-1:0] mem_wdata, xor_rest;
  logic              degraded;

  psw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  psw_lane_map #(.LANES(LANES), .STRIPES(STRIPES)) u_map (
    .rot(rot_q), .blk(blk_q), .stripe(stripe), .dlane(dlane), .plane(plane)
  );

  assign mem_addr  = AW'(stripe) * AW'(BLK_WORDS) + AW'(idx_q);
  assign mem_wdata = (state_q == ST_WPAR) ? pbuf_q[idx_q] : newb_q[idx_q];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    psw_lane_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_sn), .we(lane_wr[g]), .addr(mem_addr),
      .wdata(mem_wdata), .rdata(lane_q[g])
    );
  end

  // next-state logic
  assign last = (idx_q == IW'(BLK_WORDS-1));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cap     = 1'b0;
    case (state_q)
      ST_IDLE: if (req) begin
        cap     = 1'b1;
        idx_d   = '0;
        state_d = req_wr ? ST_OLD : ST_RD;
      end
      ST_RD, ST_OLD, ST_MIX, ST_WDAT, ST_WPAR: begin
        idx_d = last ? '0 : idx_q + IW'(1);
        if (last) begin
          case (state_q)
            ST_RD:   state_d = ST_DONE;
            ST_OLD:  state_d = ST_MIX;
            ST_MIX:  state_d = ST_WDAT;
            ST_WDAT: state_d = ST_WPAR;
            default: state_d = ST_DONE;
          endcase
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      blk_q   <= '0;
      wr_q    <= 1'b0;
      rot_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (cap) begin
        blk_q <= req_blk;
        wr_q  <= req_wr;
        rot_q <= rot_mode;
      end
    end
  end

  // block buffers: parity delta, then new parity; new data words
  always_ff @(posedge clk) begin
    if (state_q == ST_OLD) pbuf_q[idx_q] <= lane_q[dlane] ^ lane_q[plane];
    if (state_q == ST_MIX) begin
      pbuf_q[idx_q] <= pbuf_q[idx_q] ^ wd_data;
      newb_q[idx_q] <= wd_data;
    end
  end

  always_comb begin
    xor_rest = '0;
    for (int l = 0; l < LANES; l++)
      if (LW'(l) != fail_lane) xor_rest = xor_rest ^ lane_q[l];
  end

  assign degraded = fail_en && (fail_lane == dlane);
  assign rd_vld   = (state_q == ST_RD);
  assign rd_data  = degraded ? xor_rest : lane_q[dlane];
  assign wd_take  = (state_q == ST_MIX);
  assign ack      = (state_q == ST_DONE);

  always_comb begin
    lane_rd = '0;
    lane_wr = '0;
    case (state_q)
      ST_RD:   lane_rd = degraded ? ~(LANES'(1) << fail_lane) : (LANES'(1) << dlane);
      ST_OLD:  lane_rd = (LANES'(1) << dlane) | (LANES'(1) << plane);
      ST_WDAT: lane_wr = LANES'(1) << dlane;
      ST_WPAR: lane_wr = LANES'(1) << plane;
      default: ;
    endcase
  end

  // R6
  one_lane_wr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(lane_wr));
  // R6
  old_rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_OLD) |-> ($countones(lane_rd) == 2));
  // R6
  no_rd_wr_mix_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !((|lane_rd) && (|lane_wr)));
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ack |=> !ack);
  // R8
  ack_after_par_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack && wr_q) |-> $past(|lane_wr));
  // R5
  rd_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_vld && !degraded) |-> $onehot(lane_rd));
  // R9
  deg_rd_lanes_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_vld && degraded) |-> ($countones(lane_rd) == LANES-1));
endmodule

// File: tb/tb_par_stripe_writer.sv
`timescale 1ns/1ps
module tb_par_stripe_writer;
  localparam int LANES = 4, STRIPES = 8, BW_ = 4, WW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rot_mode = 0, fail_en = 0, req = 0, req_wr = 0;
  logic [1:0]  fail_lane = '0;
  logic [4:0]  req_blk = '0;
  logic [15:0] wd_data = '0;
  logic ack, wd_take, rd_vld;
  logic [15:0] rd_data;
  logic [3:0]  lane_rd, lane_wr;

  int checks = 0, fails = 0;
  logic [15:0] mdl [LANES][STRIPES][BW_];
  logic [15:0] expq [$];
  string exptag [$];

  always #2 clk = ~clk;

  par_stripe_writer #(.LANES(LANES), .STRIPES(STRIPES), .BLK_WORDS(BW_), .WORD_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .rot_mode(rot_mode), .fail_en(fail_en), .fail_lane(fail_lane),
    .req(req), .req_wr(req_wr), .req_blk(req_blk), .ack(ack), .wd_take(wd_take),
    .wd_data(wd_data), .rd_vld(rd_vld), .rd_data(rd_data), .lane_rd(lane_rd), .lane_wr(lane_wr)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // R3 / R4: parity lane; R2: data lane
  function automatic int par_lane(input int s, input bit rot);
    return rot ? (LANES-1) - (s % LANES) : LANES-1;
  endfunction
  function automatic int dat_lane(input int b, input bit rot);
    int p, k;
    p = par_lane(b / (LANES-1), rot);
    k = b % (LANES-1);
    return (k < p) ? k : k + 1;
  endfunction

  // monitor: pops expected read words
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (expq.size() == 0) chk(1'b0, "R5 unexpected word", {16'h0, rd_data}, 32'h0);
      else begin
        logic [15:0] e;
        string t;
        e = expq.pop_front();
        t = exptag.pop_front();
        chk(rd_data === e, t, {16'h0, rd_data}, {16'h0, e});
      end
    end
  end

  task automatic do_read(input int b, input bit rot, input bit fen, input int fl);
    int s, d;
    logic [3:0] erd;
    s = b / (LANES-1);
    d = dat_lane(b, rot);
    for (int w = 0; w < BW_; w++) begin
      logic [15:0] x;
      x = '0;
      if (fen && fl == d) begin
        for (int l = 0; l < LANES; l++) if (l != fl) x ^= mdl[l][s][w];
        exptag.push_back("R9 rebuilt word");
      end else begin
        x = mdl[d][s][w];
        exptag.push_back(fen ? "R10 read word" : "R5 read word");
      end
      expq.push_back(x);
    end
    erd = (fen && fl == d) ? (4'hF & ~(4'b1 << fl)) : (4'b1 << d);
    @(negedge clk);
    rot_mode = rot; fail_en = fen; fail_lane = 2'(fl);
    req = 1; req_wr = 0; req_blk = 5'(b);
    for (int w = 0; w < BW_; w++) begin
      @(negedge clk);
      chk(rd_vld === 1'b1, "R5 rd_vld", {31'h0, rd_vld}, 1);
      chk(lane_rd === erd, (fen && fl == d) ? "R9 lane_rd" : "R5 lane_rd", {28'h0, lane_rd}, {28'h0, erd});
      chk(ack === 1'b0, "R8 early ack", {31'h0, ack}, 0);
    end
    @(negedge clk);
    chk(ack === 1'b1, "R8 read ack", {31'h0, ack}, 1);
    req = 0;
    @(negedge clk);
    chk(ack === 1'b0, "R8 ack pulse", {31'h0, ack}, 0);
    fail_en = 0;
  endtask

  task automatic do_write(input int b, input bit rot, input logic [15:0] base);
    int s, d, p;
    logic [15:0] nw [BW_];
    s = b / (LANES-1);
    d = dat_lane(b, rot);
    p = par_lane(s, rot);
    for (int w = 0; w < BW_; w++) nw[w] = base ^ 16'(w * 16'h1357);
    @(negedge clk);
    rot_mode = rot; req = 1; req_wr = 1; req_blk = 5'(b);
    for (int w = 0; w < BW_; w++) begin
      @(negedge clk);
      chk(lane_rd === 4'((1 << d) | (1 << p)), "R6 old read lanes", {28'h0, lane_rd}, (1 << d) | (1 << p));
      chk(lane_wr === 4'h0, "R6 no write in old read", {28'h0, lane_wr}, 0);
    end
    for (int w = 0; w < BW_; w++) begin
      @(negedge clk);
      chk(wd_take === 1'b1, "R6 wd_take", {31'h0, wd_take}, 1);
      wd_data = nw[w];
    end
    for (int w = 0; w < BW_; w++) begin
      @(negedge clk);
      chk(lane_wr === 4'(1 << d), "R2 data lane write", {28'h0, lane_wr}, 1 << d);
    end
    for (int w = 0; w < BW_; w++) begin
      @(negedge clk);
      chk(lane_wr === 4'(1 << p), rot ? "R4 parity lane write" : "R3 parity lane write",
          {28'h0, lane_wr}, 1 << p);
      chk(ack === 1'b0, "R8 ack before parity done", {31'h0, ack}, 0);
    end
    @(negedge clk);
    chk(ack === 1'b1, "R8 write ack", {31'h0, ack}, 1);
    chk(lane_wr === 4'h0, "R6 writes stop", {28'h0, lane_wr}, 0);
    req = 0;
    @(negedge clk);
    chk(ack === 1'b0, "R8 ack pulse", {31'h0, ack}, 0);
    // R7 model update
    for (int w = 0; w < BW_; w++) begin
      mdl[p][s][w] = mdl[p][s][w] ^ mdl[d][s][w] ^ nw[w];
      mdl[d][s][w] = nw[w];
    end
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int l = 0; l < LANES; l++)
      for (int s = 0; s < STRIPES; s++)
        for (int w = 0; w < BW_; w++) mdl[l][s][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 idle outputs after reset
    chk(ack === 1'b0 && rd_vld === 1'b0 && wd_take === 1'b0, "R1 idle flags",
        {29'h0, ack, rd_vld, wd_take}, 0);
    chk(lane_rd === 4'h0 && lane_wr === 4'h0, "R1 idle lanes", {24'h0, lane_rd, lane_wr}, 0);
    // R1 contents zero
    do_read(5, 0, 0, 0);
    do_read(22, 1, 1, dat_lane(22, 1));
    // R3 fixed-mode writes
    do_write(0, 0, 16'hA5A5);
    do_write(1, 0, 16'h0F0F);
    do_write(2, 0, 16'h1234);
    do_write(4, 0, 16'hBEEF);
    do_write(23, 0, 16'hFFFF);
    do_read(0, 0, 0, 0);
    do_read(2, 0, 0, 0);
    do_read(23, 0, 0, 0);
    // R4 rotating-mode writes across stripes
    do_write(3, 1, 16'h1111);
    do_write(5, 1, 16'h2222);
    do_write(6, 1, 16'h3333);
    do_write(7, 1, 16'h4444);
    do_write(9, 1, 16'h5555);
    do_write(11, 1, 16'h6666);
    do_write(18, 1, 16'h7777);
    do_write(20, 1, 16'h8888);
    // R7 rewrite of same block
    do_write(7, 1, 16'hC3C3);
    do_read(3, 1, 0, 0);
    do_read(7, 1, 0, 0);
    do_read(18, 1, 0, 0);
    // R9 rebuild from parity, both modes
    do_read(0, 0, 1, dat_lane(0, 0));
    do_read(1, 0, 1, dat_lane(1, 0));
    do_read(5, 1, 1, dat_lane(5, 1));
    do_read(7, 1, 1, dat_lane(7, 1));
    do_read(11, 1, 1, dat_lane(11, 1));
    do_read(20, 1, 1, dat_lane(20, 1));
    // R10 failed lane is not the target
    do_read(6, 1, 1, par_lane(2, 1));
    do_read(9, 1, 1, dat_lane(10, 1));
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R5 all words seen", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule